// File: doc/BRIEF.md
# Single-Channel Peripheral/Memory Word Mover

The block is one channel of a transfer engine that copies 32-bit words between a peripheral-side port and a memory-side port. Software sets it up through six word-wide registers: a control word, a status word, a pointer and a sequencing word for each side. Writing the control word with its enable bit set while the channel is idle starts a transfer. Each cycle in which the channel may move a word, it reads the source port and writes the destination port in the same cycle. Both ports are assumed to return read data combinationally.

Two modes exist. One-shot mode moves a single buffer and then turns itself off. Continuous mode treats the buffer as two equal halves. It raises the end-of-count flag after each half, flips a ping-pong bit, and keeps running. A new base address written while it runs is adopted only when the whole buffer wraps. Pacing comes from one of up to 31 request lines, picked by a 5-bit selector. The all-ones selector value parks the channel so that the remaining count can be read safely.

Top module: `dma_ch_top`

Register word index on `reg_addr_i`: 0 control, 1 status, 2 peripheral pointer, 3 peripheral sequencing, 4 memory pointer, 5 memory sequencing.

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and no port strobe is active.
- R2: A control write with enable (bit 31) set while idle latches the word count (bits 15:2) and both pointers; status then reads busy (bit 31) set, ping-pong (bit 28) clear and remaining count (bits 15:2) equal to the programmed count.
- R3: In one-shot mode (control bit 27 set), count N moves exactly N+1 words. Word i uses address base+4i on each non-wrapping side. The channel then clears enable and busy, and the status count reads zero.
- R4: Direction bit 28 clear reads the peripheral port and writes the memory port with that data; set reads memory and writes the peripheral port. The two ports are never both written.
- R5: With flow control (control bit 21) set, a word moves in exactly those active cycles where the request line chosen by select (bits 20:16) is high. With it clear, a word moves every active cycle.
- R6: Select value 31 stops all word moves while busy stays set, the remaining count holds, and halt (status bit 29) reads set.
- R7: Hold (control bit 29) pauses the transfer with the count preserved and halt set; clearing it resumes where it stopped.
- R8: A control write with enable clear aborts the transfer: busy reads clear from the next cycle and no further word moves.
- R9: At end of count, the pending flag (status bit 30, mirrored on `irq_o`) is set if interrupt enable (control bit 30) is set and stays clear otherwise. A status write with bit 30 set clears it; a status write with bit 30 clear leaves it.
- R10: In continuous mode (bit 27 clear), end of count is reached after each half of N+1 words. The ping-pong bit toggles (set after the first half), the count reloads and busy stays set.
- R11: In continuous mode, a pointer written while running is used only after the second half completes. The following word starts at the new base.
- R12: A sequencing word wrap field (bits 18:16) value w>0 makes the side's word offset wrap modulo 2^(w+S), with S=0 for the peripheral side and S=3 for the memory side; w=0 is linear.
- R13: Pointer bits 1:0 are ignored on write and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| req_i | input | NUM_REQ | Peripheral request lines |
| irq_o | output | 1 | End-of-count pending flag |
| per_addr_o | output | 32 | Peripheral-side byte address |
| per_re_o | output | 1 | Peripheral read strobe |
| per_we_o | output | 1 | Peripheral write strobe |
| per_wdata_o | output | 32 | Peripheral write data |
| per_rdata_i | input | 32 | Peripheral read data |
| mem_addr_o | output | 32 | Memory-side byte address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The bench checks cycle by cycle that word moves match the selected request line. A gate that looked at the wrong line, or ignored flow control, would move words early or skip them. Several corner cases get directed tests:
- A count of zero: an off-by-one counter would move two words, or none.
- A pointer rewritten mid-stream in continuous mode: a design that reloaded at the half boundary would jump address too soon.
- Hold and the parking selector value: a leaky gate would let the count drift.
- Writing status with the pending bit clear: a design that cleared on any status write would lose the interrupt.

// File: rtl/dma_ch_pkg.sv
`timescale 1ns/1ps
package dma_ch_pkg;
  localparam int SEL_W = 5;
  localparam int CNT_W = 14;
  localparam int WRAP_W = 3;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_PPTR = 3'd2;
  localparam logic [2:0] A_PSEQ = 3'd3;
  localparam logic [2:0] A_MPTR = 3'd4;
  localparam logic [2:0] A_MSEQ = 3'd5;

  // control / status bit positions (software-visible layout)
  localparam int B_EN   = 31;
  localparam int B_IE   = 30;
  localparam int B_HOLD = 29;
  localparam int B_DIR  = 28;
  localparam int B_ONCE = 27;
  localparam int B_FLOW = 21;
  localparam int B_SEL  = 16;
  localparam int B_CNT  = 2;
  localparam int B_BUSY = 31;
  localparam int B_PEND = 30;
  localparam int B_HALT = 29;
  localparam int B_PING = 28;
  localparam int B_WRAP = 16;

  localparam logic [SEL_W-1:0] SEL_PARK = '1;

  typedef struct packed {
    logic             ie;
    logic             hold;
    logic             dir;
    logic             once;
    logic             flow;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] wcnt;
  } ctrl_t;
endpackage

// File: rtl/dma_ch_req_gate.sv
`timescale 1ns/1ps
module dma_ch_req_gate #(
  parameter int NUM_REQ = 16,
  parameter int SEL_W   = 5
) (
  input  logic               en_i,
  input  logic               hold_i,
  input  logic               flow_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_REQ-1:0] req_i,
  output logic               go_o,
  output logic               halt_o
);
  logic [NUM_REQ-1:0] req_sh;
  logic               sel_ok;
  logic               unused_req_hi;

  // out-of-range selects shift to zero: no requests
  assign req_sh        = req_i >> sel_i;
  assign unused_req_hi = ^req_sh[NUM_REQ-1:1];
  assign sel_ok        = (sel_i != '1);
  assign halt_o        = en_i && (hold_i || !sel_ok);
  assign go_o          = en_i && !hold_i && sel_ok && (!flow_i || req_sh[0]);
endmodule

// File: rtl/dma_ch_counter.sv
`timescale 1ns/1ps
module dma_ch_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             cont_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ping_o,
  output logic             eoc_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ping_q;

  assign eoc_o  = step_i && (cnt_q == '0);
  assign full_o = eoc_o && (ping_q || !cont_i);
  assign cnt_o  = cnt_q;
  assign ping_o = ping_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ping_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      ping_q <= 1'b0;
    end else if (eoc_o) begin
      if (cont_i) begin
        cnt_q  <= reload_val_i;
        ping_q <= ~ping_q;
      end
    end else if (step_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dma_ch_addr_gen.sv
`timescale 1ns/1ps
module dma_ch_addr_gen #(
  parameter int OFF_W      = 15,
  parameter int WRAP_W     = 3,
  parameter int WRAP_SHIFT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rebase_i,
  input  logic              step_i,
  input  logic [31:0]       base_i,
  input  logic [WRAP_W-1:0] wrap_i,
  output logic [31:0]       addr_o
);
  localparam int PAD_W = 32 - OFF_W - 2;

  logic [31:0]      base_q;
  logic [OFF_W-1:0] off_q, off_eff, mask;
  logic [31:0]      one_sh;
  int               win_bits;

  always_comb begin
    win_bits = int'(wrap_i) + WRAP_SHIFT;
    one_sh   = 32'd1 << win_bits;
    if (wrap_i == '0 || win_bits >= OFF_W) mask = '1;
    else mask = one_sh[OFF_W-1:0] - {{(OFF_W-1){1'b0}}, 1'b1};
    off_eff = off_q & mask;
  end

  assign addr_o = base_q + {{PAD_W{1'b0}}, off_eff, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load_i || (step_i && rebase_i)) begin
      base_q <= base_i;
      off_q  <= '0;
    end else if (step_i) begin
      off_q <= off_q + 1'b1;
    end
  end
endmodule

// File: rtl/dma_ch_top.sv
`timescale 1ns/1ps
module dma_ch_top
  import dma_ch_pkg::*;
#(
  parameter int NUM_REQ        = 16,
  parameter int PER_WRAP_SHIFT = 0,
  parameter int MEM_WRAP_SHIFT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_REQ-1:0] req_i,
  output logic               irq_o,
  output logic [31:0]        per_addr_o,
  output logic               per_re_o,
  output logic               per_we_o,
  output logic [31:0]        per_wdata_o,
  input  logic [31:0]        per_rdata_i,
  output logic [31:0]        mem_addr_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [31:0]        mem_wdata_o,
  input  logic [31:0]        mem_rdata_i
);
  localparam int OFF_W = CNT_W + 1;

  ctrl_t             ctrl_q;
  logic              en_q, pend_q;
  logic [31:0]       pptr_q, mptr_q;
  logic [WRAP_W-1:0] pwrap_q, mwrap_q;
  logic              wr_ctrl, wr_stat, start;
  logic              go, halt, eoc, full, ping;
  logic [CNT_W-1:0]  cnt;
  logic [1:0][31:0]       side_base, side_addr;
  logic [1:0][WRAP_W-1:0] side_wrap;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[26:22], reg_wdata_i[1:0]};
  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);
  assign start   = wr_ctrl && reg_wdata_i[B_EN] && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      pptr_q  <= '0;
      mptr_q  <= '0;
      pwrap_q <= '0;
      mwrap_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.ie   <= reg_wdata_i[B_IE];
        ctrl_q.hold <= reg_wdata_i[B_HOLD];
        ctrl_q.dir  <= reg_wdata_i[B_DIR];
        ctrl_q.once <= reg_wdata_i[B_ONCE];
        ctrl_q.flow <= reg_wdata_i[B_FLOW];
        ctrl_q.sel  <= reg_wdata_i[B_SEL +: SEL_W];
        ctrl_q.wcnt <= reg_wdata_i[B_CNT +: CNT_W];
      end
      if (wr_ctrl) en_q <= reg_wdata_i[B_EN];
      else if (eoc && ctrl_q.once) en_q <= 1'b0;
      // a new end-of-count wins over a same-cycle clear
      if (eoc && ctrl_q.ie) pend_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[B_PEND]) pend_q <= 1'b0;
      if (reg_we_i && reg_addr_i == A_PPTR) pptr_q <= {reg_wdata_i[31:2], 2'b00};
      if (reg_we_i && reg_addr_i == A_MPTR) mptr_q <= {reg_wdata_i[31:2], 2'b00};
      if (reg_we_i && reg_addr_i == A_PSEQ) pwrap_q <= reg_wdata_i[B_WRAP +: WRAP_W];
      if (reg_we_i && reg_addr_i == A_MSEQ) mwrap_q <= reg_wdata_i[B_WRAP +: WRAP_W];
    end
  end

  dma_ch_req_gate #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) u_gate (
    .en_i   (en_q),
    .hold_i (ctrl_q.hold),
    .flow_i (ctrl_q.flow),
    .sel_i  (ctrl_q.sel),
    .req_i  (req_i),
    .go_o   (go),
    .halt_o (halt)
  );

  dma_ch_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start),
    .load_val_i   (reg_wdata_i[B_CNT +: CNT_W]),
    .step_i       (go),
    .reload_val_i (ctrl_q.wcnt),
    .cont_i       (!ctrl_q.once),
    .cnt_o        (cnt),
    .ping_o       (ping),
    .eoc_o        (eoc),
    .full_o       (full)
  );

  assign side_base = {mptr_q, pptr_q};
  assign side_wrap = {mwrap_q, pwrap_q};

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_ch_addr_gen #(
      .OFF_W      (OFF_W),
      .WRAP_W     (WRAP_W),
      .WRAP_SHIFT (s == 0 ? PER_WRAP_SHIFT : MEM_WRAP_SHIFT)
    ) u_ag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (start),
      .rebase_i (full),
      .step_i   (go),
      .base_i   (side_base[s]),
      .wrap_i   (side_wrap[s]),
      .addr_o   (side_addr[s])
    );
  end

  assign per_addr_o  = side_addr[0];
  assign mem_addr_o  = side_addr[1];
  assign per_re_o    = go && !ctrl_q.dir;
  assign mem_we_o    = go && !ctrl_q.dir;
  assign mem_re_o    = go && ctrl_q.dir;
  assign per_we_o    = go && ctrl_q.dir;
  assign mem_wdata_o = per_rdata_i;
  assign per_wdata_o = mem_rdata_i;
  assign irq_o       = pend_q;

  always_comb begin
    case (reg_addr_i)
      A_CTRL: reg_rdata_o = {en_q, ctrl_q.ie, ctrl_q.hold, ctrl_q.dir, ctrl_q.once, 5'b0,
                             ctrl_q.flow, ctrl_q.sel, ctrl_q.wcnt, 2'b00};
      A_STAT: reg_rdata_o = {en_q, pend_q, halt, ping, 12'b0, cnt, 2'b00};
      A_PPTR: reg_rdata_o = pptr_q;
      A_PSEQ: reg_rdata_o = {13'b0, pwrap_q, 16'b0};
      A_MPTR: reg_rdata_o = mptr_q;
      A_MSEQ: reg_rdata_o = {13'b0, mwrap_q, 16'b0};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_ch_top_chk.sv
`timescale 1ns/1ps
module dma_ch_top_chk #(
  parameter int NUM_REQ = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [2:0]         reg_addr_i,
  input logic               wr_en_bit_i,
  input logic [NUM_REQ-1:0] req_i,
  input logic               irq_o,
  input logic               per_re_o,
  input logic               per_we_o,
  input logic               mem_re_o,
  input logic               mem_we_o,
  input logic               busy_i,
  input logic               hold_i,
  input logic               flow_i,
  input logic [4:0]         sel_i,
  input logic [13:0]        cnt_i
);
  logic [NUM_REQ-1:0] req_sh;
  logic               req_sel;
  logic               move;
  assign req_sh  = req_i >> sel_i;
  assign req_sel = req_sh[0];
  assign move    = per_we_o || mem_we_o;

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !(per_re_o || per_we_o || mem_re_o || mem_we_o));
  // R4
  p2m_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_re_o |-> (mem_we_o && !per_we_o && !mem_re_o));
  // R4
  m2p_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_we_o |-> (mem_re_o && !mem_we_o));
  // R5
  flow_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_i && !req_sel) |-> !move);
  // R6
  park_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && sel_i == 5'h1f) |=> $stable(cnt_i));
  // R7
  hold_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && hold_i) |=> $stable(cnt_i));
  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0 && !wr_en_bit_i) |=> !busy_i);
  // R9
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(busy_i));
endmodule

bind dma_ch_top dma_ch_top_chk #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wr_en_bit_i (reg_wdata_i[31]),
  .req_i       (req_i),
  .irq_o       (irq_o),
  .per_re_o    (per_re_o),
  .per_we_o    (per_we_o),
  .mem_re_o    (mem_re_o),
  .mem_we_o    (mem_we_o),
  .busy_i      (en_q),
  .hold_i      (ctrl_q.hold),
  .flow_i      (ctrl_q.flow),
  .sel_i       (ctrl_q.sel),
  .cnt_i       (cnt)
);

// File: tb/sim_dma_ch_top.sv
`timescale 1ns/1ps
module sim_dma_ch_top;
  import dma_ch_pkg::*;
  localparam int NREQ = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic             reg_we_i = 1'b0;
  logic [2:0]       reg_addr_i = '0;
  logic [31:0]      reg_wdata_i = '0;
  logic [31:0]      reg_rdata_o;
  logic [NREQ-1:0]  req_i = '0;
  logic             irq_o;
  logic [31:0]      per_addr_o, per_wdata_o, per_rdata_i;
  logic [31:0]      mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic             per_re_o, per_we_o, mem_re_o, mem_we_o;

  dma_ch_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .req_i(req_i), .irq_o(irq_o),
    .per_addr_o(per_addr_o), .per_re_o(per_re_o), .per_we_o(per_we_o),
    .per_wdata_o(per_wdata_o), .per_rdata_i(per_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] pdat(input logic [31:0] a);
    return a ^ 32'hC3A5_0F1E;
  endfunction
  function automatic logic [31:0] mdat(input logic [31:0] a);
    return a ^ 32'h1E0F_5A3C;
  endfunction
  assign per_rdata_i = pdat(per_addr_o);
  assign mem_rdata_i = mdat(mem_addr_o);

  function automatic logic [31:0] cword(input logic en, ie, hold, dir, once, flow,
                                        input logic [4:0] sel, input logic [13:0] n);
    return {en, ie, hold, dir, once, 5'b0, flow, sel, n, 2'b00};
  endfunction
  function automatic logic [31:0] sword(input logic busy, pend, halt, ping, input logic [13:0] n);
    return {busy, pend, halt, ping, 12'b0, n, 2'b00};
  endfunction
  function automatic logic [31:0] eaddr(input logic [31:0] base, input int i, input int w, input int sh);
    int o;
    o = (w == 0) ? i : (i % (1 << (w + sh)));
    return base + 32'(o * 4);
  endfunction

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // strobe monitor: logs every word move, checks pacing when enabled
  logic [31:0] lp [64];
  logic [31:0] lm [64];
  logic [31:0] ld [64];
  logic        ldir [64];
  int  nlog = 0;
  int  exp_total = 0;
  int  mon_sel = 0;
  bit  mon_flow = 1'b0;
  bit  mon_on = 1'b0;
  logic mon_s, mon_w;

  always @(negedge clk) begin
    #2;
    mon_s = per_re_o | per_we_o;
    if (mon_on) begin
      mon_w = (nlog < exp_total) && (!mon_flow || req_i[mon_sel]);
      checks++;
      if (mon_s !== mon_w) begin
        fails++;
        $display("FAIL R5 move actual=%b expected=%b word=%0d", mon_s, mon_w, nlog);
      end
    end
    if (mon_s) begin
      if (nlog < 64) begin
        lp[nlog] = per_addr_o;
        lm[nlog] = mem_addr_o;
        ldir[nlog] = per_we_o;
        ld[nlog] = per_we_o ? per_wdata_o : mem_wdata_o;
      end
      nlog++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk);
    #1 reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input int sel, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_i = NREQ'(1) << sel;
    end
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic rand_oneshot();
    logic [31:0] v, pb, mb;
    int n, sel, pw, mw;
    logic dir, flow, ie;
    n = $urandom_range(0, 20);
    sel = $urandom_range(0, NREQ - 1);
    pw = $urandom_range(0, 3);
    mw = $urandom_range(0, 1);
    dir = 1'($urandom); flow = 1'($urandom); ie = 1'($urandom);
    pb = 32'h4000_0000 | ($urandom & 32'h0000_FFFC);
    mb = 32'h8000_0000 | ($urandom & 32'h00FF_FFFC);
    wr(A_PPTR, pb); wr(A_MPTR, mb);
    wr(A_PSEQ, 32'(pw) << 16); wr(A_MSEQ, 32'(mw) << 16);
    nlog = 0; exp_total = n + 1; mon_flow = flow; mon_sel = sel;
    wr(A_CTRL, cword(1'b1, ie, 1'b0, dir, 1'b1, flow, 5'(sel), 14'(n)));
    mon_on = 1'b1;
    for (int c = 0; c < 3000 && nlog < exp_total; c++) begin
      @(negedge clk);
      req_i = NREQ'($urandom);
    end
    @(negedge clk);
    req_i = '0;
    #3 mon_on = 1'b0;
    chk("R3 word total", 32'(nlog), 32'(n + 1));
    for (int i = 0; i <= n; i++) begin
      chk(pw != 0 ? "R12 per addr" : "R3 per addr", lp[i], eaddr(pb, i, pw, 0));
      chk(mw != 0 ? "R12 mem addr" : "R3 mem addr", lm[i], eaddr(mb, i, mw, 3));
      chk("R4 direction", 32'(ldir[i]), 32'(dir));
      chk("R4 data", ld[i], dir ? mdat(lm[i]) : pdat(lp[i]));
    end
    rd(A_STAT, v); chk("R3 status done", v, sword(1'b0, ie, 1'b0, 1'b0, 14'd0));
    chk("R9 irq", 32'(irq_o), 32'(ie));
    rd(A_CTRL, v); chk("R3 enable cleared", 32'(v[31]), 32'd0);
    wr(A_STAT, 32'h0); rd(A_STAT, v); chk("R9 zero write keeps", 32'(v[30]), 32'(ie));
    wr(A_STAT, 32'h4000_0000); rd(A_STAT, v); chk("R9 clear", 32'(v[30]), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk("R1 reg zero", v, 32'h0);
    end
    chk("R1 irq low", 32'(irq_o), 32'd0);
    chk("R1 no strobe", 32'({per_re_o, per_we_o, mem_re_o, mem_we_o}), 32'd0);

    // R13 pointer alignment
    wr(A_PPTR, 32'h1000_0007); rd(A_PPTR, v); chk("R13 per ptr", v, 32'h1000_0004);
    wr(A_MPTR, 32'h2000_00FB); rd(A_MPTR, v); chk("R13 mem ptr", v, 32'h2000_00F8);

    // R2 start, R7 hold
    wr(A_PPTR, 32'h4000_0100); wr(A_MPTR, 32'h8000_0200);
    nlog = 0;
    wr(A_CTRL, cword(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3, 14'd9));
    rd(A_STAT, v); chk("R2 started", v, sword(1'b1, 1'b0, 1'b0, 1'b0, 14'd9));
    pulse(3, 2);
    rd(A_STAT, v); chk("R5 two words", v, sword(1'b1, 1'b0, 1'b0, 1'b0, 14'd7));
    wr(A_CTRL, cword(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd3, 14'd9));
    pulse(3, 3);
    rd(A_STAT, v); chk("R7 held", v, sword(1'b1, 1'b0, 1'b1, 1'b0, 14'd7));
    chk("R7 no moves", 32'(nlog), 32'd2);
    wr(A_CTRL, cword(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd3, 14'd9));
    pulse(3, 8);
    rd(A_STAT, v); chk("R7 resumed done", v, sword(1'b0, 1'b0, 1'b0, 1'b0, 14'd0));
    chk("R3 ten words", 32'(nlog), 32'd10);
    chk("R3 last per addr", lp[9], 32'h4000_0124);
    chk("R3 last mem addr", lm[9], 32'h8000_0224);

    // R6 parked select, then R8 abort
    nlog = 0;
    wr(A_CTRL, cword(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 14'd9));
    pulse(5, 3);
    wr(A_CTRL, cword(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd31, 14'd9));
    for (int k = 0; k < 4; k++) begin @(negedge clk); req_i = '1; end
    @(negedge clk); req_i = '0;
    rd(A_STAT, v); chk("R6 parked", v, sword(1'b1, 1'b0, 1'b1, 1'b0, 14'd6));
    chk("R6 no moves", 32'(nlog), 32'd3);
    wr(A_CTRL, cword(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 14'd9));
    rd(A_STAT, v); chk("R8 abort busy", v, sword(1'b0, 1'b0, 1'b0, 1'b0, 14'd6));
    nlog = 0;
    wr(A_CTRL, cword(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 14'd200));
    repeat (5) @(negedge clk);
    wr(A_CTRL, cword(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 14'd200));
    n0 = nlog;
    repeat (10) @(negedge clk);
    chk("R8 stream ran", 32'(n0 > 0), 32'd1);
    chk("R8 stream stopped", 32'(nlog), 32'(n0));
    rd(A_STAT, v); chk("R8 busy clear", 32'(v[31]), 32'd0);

    // R10 / R11 continuous mode
    wr(A_PPTR, 32'h4000_0040); wr(A_MPTR, 32'h8000_0100);
    nlog = 0;
    wr(A_CTRL, cword(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd2, 14'd3));
    pulse(2, 4);
    rd(A_STAT, v); chk("R10 first half", v, sword(1'b1, 1'b1, 1'b0, 1'b1, 14'd3));
    chk("R10 irq", 32'(irq_o), 32'd1);
    wr(A_STAT, 32'h4000_0000);
    wr(A_MPTR, 32'h8000_2000);
    pulse(2, 4);
    rd(A_STAT, v); chk("R10 second half", v, sword(1'b1, 1'b1, 1'b0, 1'b0, 14'd3));
    chk("R11 old base kept", lm[5], 32'h8000_0114);
    wr(A_STAT, 32'h4000_0000);
    pulse(2, 1);
    rd(A_STAT, v); chk("R10 reloaded", v, sword(1'b1, 1'b0, 1'b0, 1'b0, 14'd2));
    chk("R11 new base", lm[8], 32'h8000_2000);
    chk("R11 per base", lp[8], 32'h4000_0040);
    wr(A_CTRL, 32'h0);

    // random one-shot runs
    for (int t = 0; t < 40; t++) rand_oneshot();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule